// File: doc/BRIEF.md
# Shared LED / External Interrupt Pin Controller

This block owns one open-drain pad that serves two purposes. With the mode bit clear it is an LED sink: an on/off bit decides whether the pad is pulled low or left floating. With the mode bit set, the pad becomes an active-low external interrupt input. Requests are caught in a latch, and the latch is offered to the CPU whenever the global interrupt mask is clear.

The pad is first resynchronised into the core clock domain by a chain of flip-flops. A sensitivity bit selects how requests are caught. In one setting only a falling edge is caught. In the other, a falling edge or a low level is caught, which suits several wired-OR sources sharing the line. The CPU signals its vector fetch with a one-cycle acknowledge, and that pulse empties the latch. An edge that arrives during the service routine is therefore caught again. The synchronised pad level is also returned, so that branch-on-pin instructions can test it.

The three control bits are loaded together through a write strobe. Their encoding is bit 2 = interrupt mode enable, bit 1 = edge-only select, bit 0 = LED on.

Top module: `extirq_led_pin`

## Requirements
- R1: After reset the control bits are all 0, the pad is not pulled low, the request latch is empty, the CPU request is low, and `pin_level` reads 1.
- R2: `pad_pull_low` is 1 exactly when control bit 2 (mode) is 0 and control bit 0 (LED on) is 1. In interrupt mode the pad is never pulled low.
- R3: `pin_level` follows `pad_in` with a latency of two clock edges (SYNC_STAGES = 2).
- R4: With bit 2 = 1 and bit 1 = 1 (edge-only), a falling edge on `pad_in` sets `irq_pending` on the third clock edge after the change.
- R5: In edge-only mode, a pad held low does not set the latch again after an acknowledge. A new request needs the pad to rise and then fall again.
- R6: With bit 2 = 1 and bit 1 = 0 (edge-plus-level), the latch keeps getting set as long as the synchronised pad is low, so an acknowledge in that window leaves it set.
- R7: `vector_ack` empties the latch on the next edge when no trigger is present in that cycle.
- R8: A trigger in the same cycle as `vector_ack` wins, so the request is kept.
- R9: `irq_to_cpu` is high only while the latch is set, bit 2 is 1 and `cpu_imask` is 0. A masked or disabled request stays in the latch.
- R10: While bit 2 is 0, pad activity never sets the latch. Enabling interrupt mode while the pad is already low does not count as an edge in edge-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the control bits |
| cfg_wdata | input | 3 | New control bits {mode, edge_only, led_on} |
| cfg_q | output | 3 | Current control bits |
| pad_in | input | 1 | Raw level seen on the pad |
| pad_pull_low | output | 1 | 1 turns on the pad pulldown (LED lit) |
| cpu_imask | input | 1 | Global interrupt mask from the CPU |
| vector_ack | input | 1 | One-cycle pulse while the vector is fetched |
| irq_pending | output | 1 | Request latch contents |
| irq_to_cpu | output | 1 | Request presented to the CPU |
| pin_level | output | 1 | Synchronised pad level |

## Verification
Several properties are checked on every cycle by the embedded assertions: the pad is never driven in interrupt mode, the mask and the enable gate the CPU request, an acknowledge without a trigger always empties the latch, a disabled block never fills it, and each synchronised falling edge in interrupt mode fills it on the next cycle. Some behaviours can only be shown by the bench's scenarios. These are the exact latency from the pad to the latch, the refusal to re-arm in edge-only mode until the pad goes high again, the re-arming under a held low level, the collision of a trigger with an acknowledge, and the case where enable arrives while the pad is already low.

// File: rtl/extirq_led_pkg.sv
package extirq_led_pkg;

  typedef struct packed {
    logic irq_mode;   // bit 2: pad acts as interrupt input
    logic edge_only;  // bit 1: 1 = falling edge only, 0 = edge plus low level
    logic led_on;     // bit 0: LED pulldown request
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  // Pulldown is only allowed in LED mode.
  function automatic logic pulldown_on(input pin_cfg_t c);
    return (~c.irq_mode) & c.led_on;
  endfunction

  // Trigger condition for the request latch.
  function automatic logic trigger_hit(input logic mode, input logic edge_only,
                                       input logic fell, input logic lvl);
    return mode & (fell | (~edge_only & ~lvl));
  endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
  import extirq_led_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_sync,
  input  logic mode,
  input  logic edge_only,
  input  logic ack,
  output logic fall_evt,
  output logic trig,
  output logic pending
);
  logic lvl_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_prev <= 1'b1;
    else        lvl_prev <= lvl_sync;

  assign fall_evt = lvl_prev & ~lvl_sync;
  assign trig     = trigger_hit(mode, edge_only, fall_evt, lvl_sync);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= 1'b0;
    else        pending <= (pending & ~ack) | trig;

  // R7: acknowledge without trigger empties the latch
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !trig) |=> !pending);
  // R10: disabled block never fills the latch
  a_r10_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !mode) |=> !pending);
  // R4: synchronised falling edge in interrupt mode fills the latch
  a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $fell(lvl_sync)) |=> pending);
endmodule

// File: rtl/extirq_led_pin.sv
module extirq_led_pin
  import extirq_led_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             pad_in,
  output logic             pad_pull_low,
  input  logic             cpu_imask,
  input  logic             vector_ack,
  output logic             irq_pending,
  output logic             irq_to_cpu,
  output logic             pin_level
);
  pin_cfg_t cfg;
  logic     lvl_sync;
  logic     fall_evt;
  logic     trig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= pin_cfg_t'(cfg_wdata);

  extirq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (lvl_sync)
  );

  extirq_latch i_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_sync  (lvl_sync),
    .mode      (cfg.irq_mode),
    .edge_only (cfg.edge_only),
    .ack       (vector_ack),
    .fall_evt  (fall_evt),
    .trig      (trig),
    .pending   (irq_pending)
  );

  assign cfg_q        = cfg;
  assign pad_pull_low = pulldown_on(cfg);
  assign irq_to_cpu   = irq_pending & cfg.irq_mode & ~cpu_imask;
  assign pin_level    = lvl_sync;

  // R2: never drive the pad in interrupt mode
  a_r2_no_drive_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.irq_mode |-> !pad_pull_low);
  // R9: mask or disabled mode blocks the CPU request
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_imask || !cfg.irq_mode) |-> !irq_to_cpu);
  // R9: request only with a filled latch
  a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_cpu |-> irq_pending);
endmodule

// File: tb/test_extirq_led_pin.sv
module test_extirq_led_pin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_q;
  logic       pad_in = 1'b1;
  logic       pad_pull_low;
  logic       cpu_imask = 1'b0;
  logic       vector_ack = 1'b0;
  logic       irq_pending, irq_to_cpu, pin_level;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  extirq_led_pin i_extirq_led_pin (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .pad_in(pad_in), .pad_pull_low(pad_pull_low),
    .cpu_imask(cpu_imask), .vector_ack(vector_ack),
    .irq_pending(irq_pending), .irq_to_cpu(irq_to_cpu), .pin_level(pin_level)
  );

  // {cfg bits, expected pulldown}; LED lit only for mode=0, led=1
  localparam logic [3:0] LED_TBL [8] = '{
    4'b000_0, 4'b001_1, 4'b010_0, 4'b011_1,
    4'b100_0, 4'b101_0, 4'b110_0, 4'b111_0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic ack_pulse();
    vector_ack = 1'b1;
    tick(1);
    vector_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 cfg", cfg_q, 3'b000);
    check("R1 pull", {2'b0, pad_pull_low}, 3'd0);
    check("R1 pend", {2'b0, irq_pending}, 3'd0);
    check("R1 irq", {2'b0, irq_to_cpu}, 3'd0);
    check("R1 level", {2'b0, pin_level}, 3'd1);

    // R2 table walk
    for (int i = 0; i < 8; i++) begin
      write_cfg(LED_TBL[i][3:1]);
      check("R2 cfg", cfg_q, LED_TBL[i][3:1]);
      check("R2 pulldown", {2'b0, pad_pull_low}, {2'b0, LED_TBL[i][0]});
      check("R10 no latch", {2'b0, irq_pending}, 3'd0);
    end

    // R3 pin level latency; mode off so no latch (R10)
    write_cfg(3'b010);
    pad_in = 1'b0;
    tick(1);
    check("R3 lvl after 1", {2'b0, pin_level}, 3'd1);
    tick(1);
    check("R3 lvl after 2", {2'b0, pin_level}, 3'd0);
    tick(2);
    check("R10 disabled", {2'b0, irq_pending}, 3'd0);
    // R10: enable in edge-only while pad already low
    write_cfg(3'b110);
    tick(3);
    check("R10 no edge on enable", {2'b0, irq_pending}, 3'd0);

    // R4 edge-only latch timing
    pad_in = 1'b1;
    tick(4);
    pad_in = 1'b0;
    tick(2);
    check("R4 not yet", {2'b0, irq_pending}, 3'd0);
    tick(1);
    check("R4 pending", {2'b0, irq_pending}, 3'd1);
    check("R9 irq", {2'b0, irq_to_cpu}, 3'd1);
    // R9 mask and disable gate the request
    cpu_imask = 1'b1; #1;
    check("R9 masked", {2'b0, irq_to_cpu}, 3'd0);
    check("R9 kept", {2'b0, irq_pending}, 3'd1);
    cpu_imask = 1'b0;
    tick(1);
    write_cfg(3'b010);
    check("R9 disabled", {2'b0, irq_to_cpu}, 3'd0);
    check("R9 kept dis", {2'b0, irq_pending}, 3'd1);
    write_cfg(3'b110);

    // R5 held low: ack clears, no re-latch
    ack_pulse();
    tick(2);
    check("R5 held low", {2'b0, irq_pending}, 3'd0);
    pad_in = 1'b1;
    tick(4);
    check("R5 high", {2'b0, irq_pending}, 3'd0);
    pad_in = 1'b0;
    tick(3);
    check("R5 new fall", {2'b0, irq_pending}, 3'd1);

    // R8 trigger collides with ack
    pad_in = 1'b1;
    tick(4);
    pad_in = 1'b0;
    tick(2);
    ack_pulse();
    check("R8 set wins", {2'b0, irq_pending}, 3'd1);
    // R7 ack with pad high clears
    pad_in = 1'b1;
    tick(4);
    ack_pulse();
    check("R7 cleared", {2'b0, irq_pending}, 3'd0);

    // R6 edge-plus-level
    write_cfg(3'b100);
    pad_in = 1'b0;
    tick(3);
    check("R6 set", {2'b0, irq_pending}, 3'd1);
    ack_pulse();
    check("R6 still set", {2'b0, irq_pending}, 3'd1);
    tick(2);
    ack_pulse();
    check("R6 relatched", {2'b0, irq_pending}, 3'd1);
    pad_in = 1'b1;
    tick(3);
    ack_pulse();
    check("R7 level released", {2'b0, irq_pending}, 3'd0);
    check("R2 no drive irq", {2'b0, pad_pull_low}, 3'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule